// File: doc/BRIEF.md
# Multi-Counter Match Timer

This block holds a small set of independent up-counters behind one word-addressed register port. Each counter has three compare values, and any of the three can raise that counter's single interrupt line. A counter moves forward only when its chosen count tick pulses. The tick is either a fast one or a slow 32 kHz one, and only the slow tick keeps running while the chip is in deep idle. A counter either runs free and wraps past all-ones, or runs periodically and drops back to zero after it reaches its first compare value.

One shared enable register switches every counter on or off, one bit per counter. Software must turn a counter off before it loads compare or mode values. Turning the counter off clears its count, so the count starts again from zero when the counter is turned back on. The count is seen through a register that is one clock late. Software therefore reads the count until two reads agree.

Each counter is run by a three-state machine. `CNT_OFF` holds the count at zero. The `start` transition goes to `CNT_RUN` when the enable bit is set. In `CNT_RUN`, each selected tick adds one. The `hit` transition goes to `CNT_RELOAD` when, in periodic mode, a tick lands the count on compare value 0. In `CNT_RELOAD`, the `restart` transition loads zero on the next tick and returns to `CNT_RUN`. The `stop` transition goes from any state back to `CNT_OFF` when the enable bit is cleared.

Top module: `tmr_match_ctrl`

## Requirements
- R1: After reset, the enable, compare, interrupt-enable, status and mode registers are all zero, every irq line is low and rdata is zero.
- R2: The shared enable register at word address 0 holds one bit per counter, with bit c enabling counter c. A counter whose bit is clear keeps its count at zero while other counters run.
- R3: An enabled counter adds one for each pulse of its selected tick. Mode bit 1 selects the tick: 1 chooses slow_tick and 0 chooses fast_tick. Pulses on the source that is not selected do not change the count.
- R4: Clearing a counter's enable bit forces its count to zero. After the bit is set again, counting starts from zero.
- R5: Writes to a counter's compare registers or mode register are ignored while its enable bit is set.
- R6: Status bit k of a counter is set whenever a tick makes the count equal to compare value k. This includes a reload to zero. The bit stays set until software clears it.
- R7: Writing a one to a status bit clears it. When a new match arrives in the same cycle as the clear, the match wins and the bit stays set.
- R8: irq[c] is high exactly when some status bit of counter c is set and its interrupt-enable bit is also set. Status in one counter never drives another counter's line.
- R9: In periodic mode (mode bit 0 = 1), the tick after the count reaches compare value 0 loads zero, so the period is that value plus one ticks.
- R10: In free-running mode, the count wraps from all-ones to zero.
- R11: The count register returns the count as it was one clock before the read. Two reads with no tick between them return the same value.
- R12: Word map: counter c occupies the block at base 8*(c+1). Offsets 0 to 2 are the compare values, 3 is the interrupt enable, 4 is the status, 5 is the count (read-only) and 6 is the mode. Unmapped addresses and writes to the count register read back as zero. rdata is registered and updates on the clock edge that samples rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_tick | input | 1 | Single-cycle pulse of the fast count source |
| slow_tick | input | 1 | Single-cycle pulse of the 32 kHz count source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Word address |
| wdata | input | CW | Write data |
| rdata | output | CW | Registered read data |
| irq | output | NC | One interrupt line per counter |

## Verification
The checker assumes that both tick inputs are single-cycle pulses already in the clk domain. It also assumes that compare and mode values are loaded only while the counter is disabled. That second assumption is what lets the periodic bound hold: an enabled periodic count never exceeds compare value 0. The stimulus keeps within these limits. It raises each tick for exactly one clock between falling edges, and it writes compare and mode values only after the enable bit has been cleared for several cycles. The single exception is the lock check, which writes on purpose into an enabled counter so that the write is dropped.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        CNT_OFF    = 2'd0,
        CNT_RUN    = 2'd1,
        CNT_RELOAD = 2'd2
    } cnt_state_e;

    localparam int OFFW      = 3;
    localparam int MODE_PER  = 0;
    localparam int MODE_SLOW = 1;

    localparam logic [OFFW-1:0] OFF_IER  = 3'd3;
    localparam logic [OFFW-1:0] OFF_STS  = 3'd4;
    localparam logic [OFFW-1:0] OFF_CNT  = 3'd5;
    localparam logic [OFFW-1:0] OFF_MODE = 3'd6;
endpackage

// File: rtl/tmr_counter_fsm.sv
module tmr_counter_fsm
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          periodic,
    input  logic          tick,
    input  logic [CW-1:0] match0,
    output logic [CW-1:0] count,
    output logic          adv,
    output logic [CW-1:0] nxt
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    cnt_state_e    state_q, state_d;
    logic [CW-1:0] inc;

    assign inc = count + ONE;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_OFF;
        else        state_q <= state_d;
    end

    // transitions: start, hit, restart, stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_OFF: begin
                if (en) state_d = CNT_RUN;
            end
            CNT_RUN: begin
                if (!en)                                 state_d = CNT_OFF;
                else if (tick && periodic && inc == match0) state_d = CNT_RELOAD;
            end
            CNT_RELOAD: begin
                if (!en)       state_d = CNT_OFF;
                else if (tick) state_d = CNT_RUN;
            end
            default: state_d = CNT_OFF;
        endcase
    end

    // outputs of the machine
    always_comb begin
        adv = en && tick && (state_q != CNT_OFF);
        nxt = (state_q == CNT_RELOAD) ? '0 : inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        count <= '0;
        else if (!en || state_q == CNT_OFF) count <= '0;
        else if (adv)                      count <= nxt;
    end
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit #(
    parameter int CW = 32,
    parameter int NM = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   locked,
    input  logic [NM-1:0]          wr_match,
    input  logic                   wr_ier,
    input  logic                   wr_sts,
    input  logic                   wr_mode,
    input  logic [CW-1:0]          wdata,
    input  logic                   adv,
    input  logic [CW-1:0]          nxt,
    output logic [NM-1:0][CW-1:0]  match_q,
    output logic [NM-1:0]          ier_q,
    output logic [NM-1:0]          sts_q,
    output logic [1:0]             mode_q,
    output logic                   irq
);
    logic [NM-1:0] hit;
    logic [NM-1:0] clr;

    for (genvar k = 0; k < NM; k++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     match_q[k] <= '0;
            else if (wr_match[k] && !locked) match_q[k] <= wdata;
        end
        assign hit[k] = adv && (nxt == match_q[k]);
    end

    assign clr = wr_sts ? wdata[NM-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_q  <= '0;
            sts_q  <= '0;
            mode_q <= '0;
        end else begin
            if (wr_ier)            ier_q  <= wdata[NM-1:0];
            if (wr_mode && !locked) mode_q <= wdata[1:0];
            sts_q <= (sts_q & ~clr) | hit;
        end
    end

    assign irq = |(sts_q & ier_q);
endmodule

// File: rtl/tmr_match_ctrl.sv
module tmr_match_ctrl
    import tmr_pkg::*;
#(
    parameter int NC = 3,
    parameter int NM = 3,
    parameter int CW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fast_tick,
    input  logic          slow_tick,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    output logic [NC-1:0] irq
);
    localparam int BLKW = AW - OFFW;

    logic [BLKW-1:0] blk;
    logic [OFFW-1:0] off;
    assign blk = addr[AW-1:OFFW];
    assign off = addr[OFFW-1:0];

    logic [NC-1:0]                  en_q, tick_w, per_w, sts_wr_w, adv_w;
    logic [NC-1:0][CW-1:0]          cnt_w, m0_w, nxt_w, shd_q;
    logic [NC-1:0][NM-1:0][CW-1:0]  match_w;
    logic [NC-1:0][NM-1:0]          ier_w, sts_w;
    logic [NC-1:0][1:0]             mode_w;
    logic [CW-1:0]                  rd_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    en_q <= '0;
        else if (wr_en && addr == '0)  en_q <= wdata[NC-1:0];
    end

    for (genvar c = 0; c < NC; c++) begin : g_cnt
        localparam logic [BLKW-1:0] BLK_ID = BLKW'(c + 1);
        logic          sel;
        logic [NM-1:0] wr_m;

        assign sel = (blk == BLK_ID);
        for (genvar k = 0; k < NM; k++) begin : g_wm
            assign wr_m[k] = wr_en && sel && (off == OFFW'(k));
        end
        assign sts_wr_w[c] = wr_en && sel && (off == OFF_STS);
        assign tick_w[c]   = mode_w[c][MODE_SLOW] ? slow_tick : fast_tick;
        assign per_w[c]    = mode_w[c][MODE_PER];
        assign m0_w[c]     = match_w[c][0];

        tmr_counter_fsm #(.CW(CW)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_q[c]),
            .periodic (per_w[c]),
            .tick     (tick_w[c]),
            .match0   (m0_w[c]),
            .count    (cnt_w[c]),
            .adv      (adv_w[c]),
            .nxt      (nxt_w[c])
        );

        tmr_match_unit #(.CW(CW), .NM(NM)) u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .locked   (en_q[c]),
            .wr_match (wr_m),
            .wr_ier   (wr_en && sel && (off == OFF_IER)),
            .wr_sts   (sts_wr_w[c]),
            .wr_mode  (wr_en && sel && (off == OFF_MODE)),
            .wdata    (wdata),
            .adv      (adv_w[c]),
            .nxt      (nxt_w[c]),
            .match_q  (match_w[c]),
            .ier_q    (ier_w[c]),
            .sts_q    (sts_w[c]),
            .mode_q   (mode_w[c]),
            .irq      (irq[c])
        );

        // bus-side copy of the count, one clock behind
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) shd_q[c] <= '0;
            else        shd_q[c] <= cnt_w[c];
        end
    end

    always_comb begin
        rd_val = '0;
        if (addr == '0) rd_val = CW'(en_q);
        for (int c = 0; c < NC; c++) begin
            if (blk == BLKW'(c + 1)) begin
                for (int k = 0; k < NM; k++) begin
                    if (off == OFFW'(k)) rd_val = match_w[c][k];
                end
                if (off == OFF_IER)  rd_val = CW'(ier_w[c]);
                if (off == OFF_STS)  rd_val = CW'(sts_w[c]);
                if (off == OFF_CNT)  rd_val = shd_q[c];
                if (off == OFF_MODE) rd_val = CW'(mode_w[c]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end
endmodule

// File: rtl/tmr_match_ctrl_chk.sv
module tmr_match_ctrl_chk #(
    parameter int NC = 3,
    parameter int NM = 3,
    parameter int CW = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NC-1:0]         en_q,
    input logic [NC-1:0]         tick_w,
    input logic [NC-1:0]         per_w,
    input logic [NC-1:0]         sts_wr_w,
    input logic [NC-1:0][CW-1:0] cnt_w,
    input logic [NC-1:0][CW-1:0] m0_w,
    input logic [NC-1:0][NM-1:0] sts_w
);
    for (genvar c = 0; c < NC; c++) begin : g_c
        p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(en_q[c]) && !$past(tick_w[c])) |-> $stable(cnt_w[c]));

        p_off_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(en_q[c]) && !en_q[c]) |-> (cnt_w[c] == '0));

        p_match_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(en_q[c]) |-> $stable(m0_w[c]));

        p_period_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q[c] && per_w[c]) |-> (cnt_w[c] <= m0_w[c]));

        for (genvar k = 0; k < NM; k++) begin : g_k
            p_sts_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(sts_w[c][k]) && !$past(sts_wr_w[c])) |-> sts_w[c][k]);
        end
    end
endmodule

bind tmr_match_ctrl tmr_match_ctrl_chk #(.NC(NC), .NM(NM), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_q     (en_q),
    .tick_w   (tick_w),
    .per_w    (per_w),
    .sts_wr_w (sts_wr_w),
    .cnt_w    (cnt_w),
    .m0_w     (m0_w),
    .sts_w    (sts_w)
);

// File: tb/tmr_match_ctrl_test.sv
`timescale 1ns/1ps
module tmr_match_ctrl_test;
    localparam int CW = 8;
    localparam int AW = 6;
    localparam int NC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fast_tick = 1'b0, slow_tick = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic [NC-1:0] irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tmr_match_ctrl #(.NC(NC), .NM(3), .CW(CW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic [AW-1:0] a;
        logic [CW-1:0] d;
        logic [CW-1:0] e;
    } vec_t;

    // R12 map walk on disabled counter 1 (block base 16)
    localparam vec_t TBL [10] = '{
        '{6'd16, 8'h11, 8'h11},
        '{6'd17, 8'h22, 8'h22},
        '{6'd18, 8'h33, 8'h33},
        '{6'd19, 8'h05, 8'h05},
        '{6'd22, 8'h03, 8'h03},
        '{6'd21, 8'h44, 8'h00},
        '{6'd20, 8'hFF, 8'h00},
        '{6'd23, 8'h09, 8'h00},
        '{6'd1,  8'h5A, 8'h00},
        '{6'd0,  8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [CW-1:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic ftick(input int n);
        repeat (n) begin
            @(negedge clk); fast_tick = 1'b1;
            @(negedge clk); fast_tick = 1'b0;
        end
    endtask

    task automatic stick(input int n);
        repeat (n) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [CW-1:0] v, v2;
        idle(3);
        chk("R1 rdata", 32'(rdata), 0);
        chk("R1 irq", 32'(irq), 0);
        rst_n = 1'b1;
        idle(2);
        rd(0, v);  chk("R1 enable", 32'(v), 0);
        rd(13, v); chk("R1 count0", 32'(v), 0);
        rd(11, v); chk("R1 ier0", 32'(v), 0);

        for (int i = 0; i < 10; i++) begin
            wr(TBL[i].a, TBL[i].d);
            rd(TBL[i].a, v);
            chk($sformatf("R12 entry %0d", i), 32'(v), 32'(TBL[i].e));
        end

        // counter 0: free running, fast tick
        wr(8, 5); wr(9, 3); wr(10, 200); wr(14, 0);
        wr(0, 1);
        idle(3);
        ftick(4);
        idle(2);
        rd(13, v); rd(13, v2);
        chk("R3 count after 4 fast", 32'(v), 4);
        chk("R11 reads agree", 32'(v2), 32'(v));
        stick(3); idle(2);
        rd(13, v); chk("R3 slow ignored", 32'(v), 4);
        rd(12, v); chk("R6 match1 status", 32'(v), 2);
        chk("R8 masked", 32'(irq), 0);
        wr(11, 2);
        chk("R8 own line", 32'(irq), 1);
        wr(12, 2);
        chk("R7 irq after clear", 32'(irq), 0);
        rd(12, v); chk("R7 w1c", 32'(v), 0);

        wr(8, 9);  rd(8, v);  chk("R5 match locked", 32'(v), 5);
        wr(14, 1); rd(14, v); chk("R5 mode locked", 32'(v), 0);

        ftick(1); idle(2);
        rd(12, v); chk("R6 match0 status", 32'(v), 1);
        chk("R8 bit0 not enabled", 32'(irq), 0);

        ftick(250); idle(2);
        rd(13, v); chk("R10 all ones", 32'(v), 255);
        ftick(1); idle(2);
        rd(13, v); chk("R10 wrap", 32'(v), 0);
        wr(12, 7);
        ftick(2);
        @(negedge clk); fast_tick = 1'b1; wr_en = 1'b1; addr = 12; wdata = 2;
        @(negedge clk); fast_tick = 1'b0; wr_en = 1'b0;
        idle(1);
        rd(12, v); chk("R7 set wins", 32'(v), 2);

        wr(0, 0); idle(3);
        rd(13, v); chk("R4 disabled zero", 32'(v), 0);
        wr(0, 1); idle(3);
        ftick(2); idle(2);
        rd(13, v); chk("R4 restart", 32'(v), 2);
        wr(0, 0); idle(3);
        wr(12, 7);

        // counter 2: periodic, slow tick, match0 = 3
        wr(24, 3); wr(30, 3);
        wr(0, 4); idle(3);
        stick(3); idle(2);
        rd(29, v); chk("R9 at match0", 32'(v), 3);
        stick(1); idle(2);
        rd(29, v); chk("R9 reload", 32'(v), 0);
        stick(4); idle(2);
        rd(29, v); chk("R9 full period", 32'(v), 0);
        ftick(2); idle(2);
        rd(29, v); chk("R3 fast ignored", 32'(v), 0);
        rd(28, v); chk("R6 reload hits zero compares", 32'(v), 7);
        rd(0, v);  chk("R2 enable readback", 32'(v), 4);
        rd(13, v); chk("R2 other counter idle", 32'(v), 0);
        chk("R8 no lines", 32'(irq), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule